// File: doc/BRIEF.md
# Operand Extend-and-Scale Stage

This block conditions a register value before it is used as an address offset. It reduces the value to a chosen low-order width and widens it back to the full data width. Zero or sign fill is used for the upper bits. The widened value is then scaled by a small left shift, and the result is held in one output register with a valid flag.

A 3-bit option input drives the conditioning. Its low two bits pick the source width, and its top bit picks sign or zero fill. A separate shift input sets the scale. The stage adds one clock of latency, and a result is captured only in cycles where the input is marked valid. Adding the base register and accessing memory happen in the stages that follow, not here.

Top module: `xs_unit`

## Requirements
- R1: With option bits [1:0] = 0 (8-bit source) and option bit [2] = 0, bits 63:8 of the result are zero and bits 7:0 equal the input's bits 7:0, before shifting.
- R2: Option bits [1:0] = 1 selects a 16-bit source, and option bits [1:0] = 2 selects a 32-bit source. When option bit [2] = 0, the bits above the source width are zero.
- R3: When option bit [2] = 1 and the width code is 0, 1 or 2, every bit above the source width is a copy of the source's top bit (bit 7, 15 or 31).
- R4: With width code 3, the 64-bit input passes through whole, whatever value option bit [2] has.
- R5: The extended value is shifted left by the shift amount after extension. Bits moved past bit 63 are lost, and zeros enter at the bottom.
- R6: A shift amount of 0 outputs the extended value unchanged.
- R7: A shift amount above MAX_SHIFT (default 4) acts as MAX_SHIFT.
- R8: out_valid is in_valid delayed by exactly one clock. out_data shows the result for the inputs sampled at that edge.
- R9: While in_valid is low, out_data keeps its last value and ignores changes on in_data, in_opt and in_shamt.
- R10: A synchronous active-high rst clears out_valid and out_data at the next clock edge, even if in_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is valid |
| in_data | input | 64 | Register value to condition |
| in_opt | input | 3 | [2] sign fill, [1:0] source width code |
| in_shamt | input | 3 | Left shift amount, 0..MAX_SHIFT |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_data | output | 64 | Extended and shifted result |

## Verification
The bench builds two copies with default widths (64-bit data, 3-bit shift field, MAX_SHIFT 4). One uses the staged logarithmic shifter and the other uses the candidate-select shifter, so both generate variants run against one reference. Because the shift field is 3 bits wide, the bench can drive amounts 5 to 7, which exercises the clamp to MAX_SHIFT. The patterns include values with the top bit set at each source width, which exercises the sign-fill boundaries, and a 4-bit shift of a full-width value, which pushes set bits past bit 63.

// File: rtl/xs_pkg.sv
package xs_pkg;

   typedef enum logic [1:0] {
      XW_B8   = 2'd0,
      XW_B16  = 2'd1,
      XW_B32  = 2'd2,
      XW_FULL = 2'd3
   } xw_code_e;

   typedef struct packed {
      logic     sign_fill;
      xw_code_e width;
   } xopt_t;

   localparam int XS_SHIFT_LOG = 0;
   localparam int XS_SHIFT_MUX = 1;

endpackage

// File: rtl/xs_extend.sv
module xs_extend
   import xs_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int SRC_A  = 8,
   parameter int SRC_B  = 16,
   parameter int SRC_C  = 32
) (
   input  logic [DATA_W-1:0] din,
   input  xopt_t             opt,
   output logic [DATA_W-1:0] dout
);
   localparam int PAD_A = DATA_W - SRC_A;
   localparam int PAD_B = DATA_W - SRC_B;
   localparam int PAD_C = DATA_W - SRC_C;

   logic fill_a, fill_b, fill_c;

   assign fill_a = opt.sign_fill & din[SRC_A-1];
   assign fill_b = opt.sign_fill & din[SRC_B-1];
   assign fill_c = opt.sign_fill & din[SRC_C-1];

   always_comb begin
      unique case (opt.width)
         XW_B8:   dout = {{PAD_A{fill_a}}, din[SRC_A-1:0]};
         XW_B16:  dout = {{PAD_B{fill_b}}, din[SRC_B-1:0]};
         XW_B32:  dout = {{PAD_C{fill_c}}, din[SRC_C-1:0]};
         default: dout = din;
      endcase
   end
endmodule

// File: rtl/xs_shift.sv
module xs_shift
   import xs_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int SHAMT_W   = 3,
   parameter int MAX_SHIFT = 4,
   parameter int STYLE     = XS_SHIFT_LOG
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHAMT_W-1:0] amt,
   output logic [DATA_W-1:0]  dout
);
   localparam logic [SHAMT_W-1:0] AMT_CAP = SHAMT_W'(MAX_SHIFT);

   logic [SHAMT_W-1:0] amt_eff;

   assign amt_eff = (amt > AMT_CAP) ? AMT_CAP : amt;

   generate
      if (STYLE == XS_SHIFT_LOG) begin : g_log
         logic [DATA_W-1:0] stage [0:SHAMT_W];
         assign stage[0] = din;
         for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
            assign stage[k+1] = amt_eff[k] ? (stage[k] << (1 << k)) : stage[k];
         end
         assign dout = stage[SHAMT_W];
      end else begin : g_mux
         logic [DATA_W-1:0] cand [0:MAX_SHIFT];
         for (genvar i = 0; i <= MAX_SHIFT; i++) begin : g_cand
            assign cand[i] = din << i;
         end
         always_comb begin
            dout = cand[0];
            for (int i = 1; i <= MAX_SHIFT; i++) begin
               if (amt_eff == SHAMT_W'(i)) dout = cand[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/xs_outreg.sv
module xs_outreg #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              d_valid,
   input  logic [DATA_W-1:0] d_data,
   output logic              q_valid,
   output logic [DATA_W-1:0] q_data
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_valid <= 1'b0;
         q_data  <= '0;
      end else begin
         q_valid <= d_valid;
         if (d_valid) q_data <= d_data;
      end
   end

   a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
      d_valid |=> q_valid);
   a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
      !d_valid |=> !q_valid);
   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !d_valid |=> $stable(q_data));
   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (!q_valid && q_data == '0));
endmodule

// File: rtl/xs_unit.sv
module xs_unit
   import xs_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int SHAMT_W     = 3,
   parameter int MAX_SHIFT   = 4,
   parameter int SRC_A       = 8,
   parameter int SRC_B       = 16,
   parameter int SRC_C       = 32,
   parameter int SHIFT_STYLE = XS_SHIFT_LOG
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  in_data,
   input  logic [2:0]         in_opt,
   input  logic [SHAMT_W-1:0] in_shamt,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_data
);
   generate
      if (!(SRC_A > 0 && SRC_A < SRC_B && SRC_B < SRC_C && SRC_C < DATA_W))
         begin : g_bad_src
         $error("xs_unit: source widths must rise strictly below DATA_W");
      end
      if (MAX_SHIFT < 0 || MAX_SHIFT >= (1 << SHAMT_W) || MAX_SHIFT >= DATA_W)
         begin : g_bad_shift
         $error("xs_unit: MAX_SHIFT must fit the shift field and the data");
      end
      if (SHIFT_STYLE != XS_SHIFT_LOG && SHIFT_STYLE != XS_SHIFT_MUX)
         begin : g_bad_style
         $error("xs_unit: unknown SHIFT_STYLE");
      end
   endgenerate

   xopt_t             opt_s;
   logic [DATA_W-1:0] ext_val;
   logic [DATA_W-1:0] shf_val;

   assign opt_s = xopt_t'(in_opt);

   xs_extend #(
      .DATA_W(DATA_W), .SRC_A(SRC_A), .SRC_B(SRC_B), .SRC_C(SRC_C)
   ) u_ext (
      .din (in_data),
      .opt (opt_s),
      .dout(ext_val)
   );

   xs_shift #(
      .DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .MAX_SHIFT(MAX_SHIFT),
      .STYLE(SHIFT_STYLE)
   ) u_shf (
      .din (ext_val),
      .amt (in_shamt),
      .dout(shf_val)
   );

   xs_outreg #(.DATA_W(DATA_W)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .d_valid(in_valid),
      .d_data (shf_val),
      .q_valid(out_valid),
      .q_data (out_data)
   );

   // R4: full-width code with no shift returns the sampled input whole
   a_r4_passthrough: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_opt[1:0] == 2'd3 && in_shamt == '0)
      |=> out_data == $past(in_data));
   // R1: zero-filled byte source leaves the upper bits clear
   a_r1_byte_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_opt == 3'b000 && in_shamt == '0)
      |=> (out_data[DATA_W-1:SRC_A] == '0 && out_data[SRC_A-1:0] == $past(in_data[SRC_A-1:0])));
   // R5: after any shift, the low bits below the amount are zero
   a_r5_low_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_shamt != '0) |=> out_data[0] == 1'b0);
endmodule

// File: tb/xs_unit_tb_top.sv
module xs_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [63:0] in_data;
   logic [2:0]  in_opt;
   logic [2:0]  in_shamt;
   logic        out_valid, out_valid_m;
   logic [63:0] out_data, out_data_m;

   int checks = 0;
   int errors = 0;

   logic        m_valid;
   logic [63:0] m_data;

   always #5 clk = ~clk;

   xs_unit #(.SHIFT_STYLE(0)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_opt(in_opt), .in_shamt(in_shamt),
      .out_valid(out_valid), .out_data(out_data));

   xs_unit #(.SHIFT_STYLE(1)) dut_mux_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_opt(in_opt), .in_shamt(in_shamt),
      .out_valid(out_valid_m), .out_data(out_data_m));

   function automatic logic [63:0] ref_val(logic [63:0] d, logic [2:0] o, logic [2:0] s);
      int          w;
      logic [63:0] mask;
      logic [63:0] x;
      int          sh;
      case (o[1:0])
         2'd0: w = 8;
         2'd1: w = 16;
         2'd2: w = 32;
         default: w = 64;
      endcase
      x = d;
      if (w < 64) begin
         mask = (64'd1 << w) - 64'd1;
         x = d & mask;
         if (o[2] && d[w-1]) x = x | ~mask;
      end
      sh = (int'(s) > 4) ? 4 : int'(s);
      return x << sh;
   endfunction

   task automatic compare(string tag);
      checks++;
      if (out_valid !== m_valid || out_data !== m_data) begin
         errors++;
         $display("FAIL %s log-shifter: valid=%0b data=%h expected valid=%0b data=%h",
                  tag, out_valid, out_data, m_valid, m_data);
      end
      checks++;
      if (out_valid_m !== m_valid || out_data_m !== m_data) begin
         errors++;
         $display("FAIL %s mux-shifter: valid=%0b data=%h expected valid=%0b data=%h",
                  tag, out_valid_m, out_data_m, m_valid, m_data);
      end
   endtask

   task automatic step(logic r, logic v, logic [63:0] d, logic [2:0] o, logic [2:0] s, string tag);
      rst = r; in_valid = v; in_data = d; in_opt = o; in_shamt = s;
      @(posedge clk);
      if (r) begin
         m_valid = 1'b0;
         m_data  = '0;
      end else begin
         m_valid = v;
         if (v) m_data = ref_val(d, o, s);
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL R8 watchdog expired: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] lf;
      m_valid = 1'b0; m_data = '0;
      rst = 1'b1; in_valid = 1'b0; in_data = '0; in_opt = '0; in_shamt = '0;
      @(negedge clk);
      step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 3'b111, 3'd0, "R10 reset with valid high");
      step(0, 1, 64'h1234_5678_9ABC_DEF1, 3'b000, 3'd0, "R1 byte zero");
      step(0, 1, 64'hFFFF_FFFF_FFFF_FF80, 3'b000, 3'd0, "R1 byte zero top set");
      step(0, 1, 64'h0000_0000_0012_8001, 3'b001, 3'd0, "R2 half zero");
      step(0, 1, 64'hFFFF_FFFF_8000_0001, 3'b010, 3'd0, "R2 word zero");
      step(0, 1, 64'h0000_0000_0000_0080, 3'b100, 3'd0, "R3 byte sign neg");
      step(0, 1, 64'hFFFF_FFFF_FFFF_FF7F, 3'b100, 3'd0, "R3 byte sign pos");
      step(0, 1, 64'h0000_0000_0000_8000, 3'b101, 3'd0, "R3 half sign");
      step(0, 1, 64'h0000_0000_8000_0000, 3'b110, 3'd0, "R3 word sign");
      step(0, 1, 64'h8000_0000_0000_0001, 3'b111, 3'd0, "R4 full signed code");
      step(0, 1, 64'h8000_0000_0000_0001, 3'b011, 3'd0, "R4 full unsigned code");
      step(0, 1, 64'hF000_0000_0000_000F, 3'b011, 3'd4, "R5 overflow discarded");
      step(0, 1, 64'h0000_0000_0000_0080, 3'b100, 3'd3, "R5 sign then shift");
      step(0, 1, 64'h0000_0000_0000_00FF, 3'b000, 3'd0, "R6 zero shift");
      step(0, 1, 64'h0000_0000_0000_0001, 3'b011, 3'd7, "R7 clamp 7");
      step(0, 1, 64'h0000_0000_0000_0003, 3'b001, 3'd5, "R7 clamp 5");
      step(0, 0, 64'hDEAD_BEEF_0000_1111, 3'b011, 3'd1, "R9 hold idle");
      step(0, 0, 64'h0BAD_F00D_2222_3333, 3'b100, 3'd2, "R9 hold idle again");
      step(0, 1, 64'h0000_0000_0000_0042, 3'b000, 3'd1, "R8 valid after idle");
      step(1, 1, 64'h1111_1111_1111_1111, 3'b011, 3'd0, "R10 mid-run reset");
      lf = 64'hACE1_2468_1357_9BDF;
      for (int i = 0; i < 300; i++) begin
         lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
         step(0, lf[5] | lf[9], lf, lf[2:0], lf[12:10], "R8 mixed stream");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule